// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the software-visible face of a serial port. A simple word-oriented register bus (byte address, write enable, read strobe, write data, combinational read data) reaches four control words, a FIFO-control word, baud and timing words, two status words, a test-status word and a single-character receive holding buffer. Characters written to the transmit-data slot leave through a valid/ready byte handshake toward a serializer. Characters arriving from the line side come in through a second valid/ready handshake, and a separate break input turns a handshake into a break event. One level-sensitive interrupt line summarizes the status flags that software has enabled.

The receive path holds exactly one character. Software clears event bits in the status words by writing ones. A control-2 write with its active-low soft-reset bit at zero returns all status to its reset state. Baud generation, line timing and real FIFOs live elsewhere. The baud, timing and FIFO words only have to read back what software stored.

Top module: `serial_regfront`

## Requirements
- R1: The register is chosen by the byte address shifted right by two, and address bits 1:0 are ignored. Word indices: control 1..4 at 0x20..0x23, FIFO control 0x24, baud modulator 0x2A, one-millisecond 0x2C. Each of these stores the low 16 bits of a write and reads them back zero-extended. A write to the baud-increment index 0x29 is read back at the baud-count index 0x2B.
- R2: Unknown indices, and reads of 0x29, return 0 with no side effect. Writes to the test-status index 0x2D, the baud-count index 0x2B and unknown indices change nothing.
- R3: After reset, status 1 reads 0x2040: transmit-ready at bit 13 and receive-data-state at bit 6. Status 2 reads 0x4028: transmit-empty at bit 14, transmit-complete at bit 3 and carrier-in at bit 5. Test status reads 0x0060: receive-empty at bit 5 and transmit-empty at bit 6. The receive word reads 0x8000, which is the error flag. Control 1 reads 0x0001 (enable), and the other control words read 0.
- R4: `rxReady` equals NOT status-1 receive-ready (bit 9). An accepted character is stored as {8'h00, char}, sets receive-ready and status-2 data-ready (bit 0), and clears receive-empty. An offer made while the buffer is full leaves the buffer unchanged.
- R5: A read of index 0x00 while receive-empty is clear returns the word, clears receive-ready and data-ready, and sets receive-empty. A read while it is set returns the stored word and changes nothing.
- R6: An accepted offer with `rxBreak` high stores 0x9800 (error bit 15, framing bit 12, break bit 11), and sets status-2 break-detected (bit 2).
- R7: A write to index 0x10 while control-2 transmit-enable (bit 2) is set raises `txValid`, holds the byte on `txData`, and clears transmit-ready and transmit-complete. Both flags return when the handshake completes. With transmit-enable clear, or with a byte still pending, the write is dropped.
- R8: Writing ones to status 1 clears only bits in mask 0x9590. Writing ones to status 2 clears only bits in mask 0xBF96, which includes break-detected. All other status bits ignore writes.
- R9: `irq` is high when status 1 AND control 1 is nonzero at bit 13 or bit 9. It is also high when status 2 has a set bit that is enabled: transmit-empty (bit 14) is enabled by control-1 bit 6, and transmit-complete (bit 3) and data-ready (bit 0) are enabled by control-4 bits 3 and 0.
- R10: A control-2 write with bit 0 low restores status 1, status 2, test status and the receive word to their reset values and drops a pending transmit byte. The control words keep their values, and control 2 takes the written value.
- R11: Read data is valid in the same cycle as the address, and a read side effect takes hold at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-up reset |
| busAddr | input | ADDR_W | Byte address |
| busWe | input | 1 | Write enable |
| busRe | input | 1 | Read strobe (needed for read side effects) |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational from address |
| txValid | output | 1 | Transmit byte pending |
| txReady | input | 1 | Serializer takes the byte |
| txData | output | CHAR_W | Transmit byte |
| rxValid | input | 1 | Receive character or break offered |
| rxReady | output | 1 | Holding buffer is free |
| rxData | input | CHAR_W | Received character |
| rxBreak | input | 1 | Offer is a break event |
| irq | output | 1 | Level interrupt |

## Verification
The bench offers a second character while the buffer is full and expects the first one back. A design that overwrote the buffer would return the wrong byte. It reads the receive word while the buffer is empty, where a design that skipped the empty check would flip the status flags. It writes all-ones to both status words, which would wipe the transmit-ready and data-ready flags if the clear masks were wrong. It writes a second transmit byte while one is pending and expects the byte on `txData` to stay the same. It also fires a soft reset while a receive is held and a transmit is pending. A design that cleared the control words there, or kept the transmit pending, would show the wrong values or a stuck `txValid`.

// File: rtl/serial_regfront_pkg.sv
package serial_regfront_pkg;

  localparam int REG_W    = 16;
  localparam int NUM_CTRL = 4;
  localparam int CSEL_W   = $clog2(NUM_CTRL);

  // word indices (byte address >> 2)
  localparam int IDX_RXWORD  = 'h00;
  localparam int IDX_TXWORD  = 'h10;
  localparam int IDX_CTRL1   = 'h20;
  localparam int IDX_FIFO    = 'h24;
  localparam int IDX_STAT1   = 'h25;
  localparam int IDX_STAT2   = 'h26;
  localparam int IDX_BAUDINC = 'h29;
  localparam int IDX_BAUDMOD = 'h2A;
  localparam int IDX_BAUDCNT = 'h2B;
  localparam int IDX_ONEMS   = 'h2C;
  localparam int IDX_TEST    = 'h2D;

  // status 1 / control 1 share these two positions
  localparam int B_TXRDY   = 13;
  localparam int B_RXRDY   = 9;
  localparam int B_RXSTATE = 6;
  // status 2 / control 4 share bits 3 and 0
  localparam int B_DATARDY = 0;
  localparam int B_BRKDET  = 2;
  localparam int B_TXDONE  = 3;
  localparam int B_CARRIER = 5;
  localparam int B_TXEMPTY = 14;
  // control bits
  localparam int B_ENABLE    = 0;
  localparam int B_TXEMPTYIE = 6;
  localparam int B_SRSTN     = 0;
  localparam int B_TXEN      = 2;
  localparam int C4_SLOT     = 3;
  // test status
  localparam int B_TS_RXEMPTY = 5;
  localparam int B_TS_TXEMPTY = 6;
  // receive word flags
  localparam int B_RW_ERR = 15;
  localparam int B_RW_OVR = 13;
  localparam int B_RW_FRM = 12;
  localparam int B_RW_BRK = 11;

  localparam logic [REG_W-1:0] STAT1_RST = REG_W'((1 << B_TXRDY) | (1 << B_RXSTATE));
  localparam logic [REG_W-1:0] STAT2_RST = REG_W'((1 << B_TXEMPTY) | (1 << B_TXDONE) | (1 << B_CARRIER));
  localparam logic [REG_W-1:0] TEST_RST  = REG_W'((1 << B_TS_RXEMPTY) | (1 << B_TS_TXEMPTY));
  localparam logic [REG_W-1:0] RXW_RST   = REG_W'(1 << B_RW_ERR);
  localparam logic [REG_W-1:0] BRK_WORD  = REG_W'((1 << B_RW_ERR) | (1 << B_RW_FRM) | (1 << B_RW_BRK));
  localparam logic [REG_W-1:0] STAT1_W1C = 16'h9590;
  localparam logic [REG_W-1:0] STAT2_W1C = 16'hBF96;
  localparam logic [REG_W-1:0] S1_IRQ_MASK = REG_W'((1 << B_TXRDY) | (1 << B_RXRDY));
  localparam logic [REG_W-1:0] C4_IRQ_MASK = REG_W'((1 << B_TXDONE) | (1 << B_DATARDY));

  typedef struct packed {
    logic [NUM_CTRL-1:0] wrCtrl;
    logic wrFifo;
    logic wrStat1;
    logic wrStat2;
    logic wrBaudInc;
    logic wrBaudMod;
    logic wrOneMs;
    logic wrTx;
    logic rdRx;
    logic softRst;
  } strobe_t;

  typedef enum logic [3:0] {
    RD_ZERO, RD_RXWORD, RD_CTRL, RD_FIFO, RD_STAT1, RD_STAT2,
    RD_BAUDMOD, RD_BAUDCNT, RD_ONEMS, RD_TEST
  } rd_sel_e;

endpackage

// File: rtl/serial_regfront_ctrl.sv
module serial_regfront_ctrl
  import serial_regfront_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic              srstBit,
  output strobe_t           strb,
  output rd_sel_e           rdSel,
  output logic [CSEL_W-1:0] ctrlSel
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] regIdx;
  logic [31:0]      idx;
  logic             unusedLowAddr;

  assign regIdx        = busAddr[ADDR_W-1:2];
  assign idx           = 32'(regIdx);
  assign unusedLowAddr = ^busAddr[1:0];

  always_comb begin
    strb    = '0;
    rdSel   = RD_ZERO;
    ctrlSel = '0;
    case (idx)
      IDX_RXWORD:  begin rdSel = RD_RXWORD;  strb.rdRx      = busRe; end
      IDX_TXWORD:  begin                     strb.wrTx      = busWe; end
      IDX_FIFO:    begin rdSel = RD_FIFO;    strb.wrFifo    = busWe; end
      IDX_STAT1:   begin rdSel = RD_STAT1;   strb.wrStat1   = busWe; end
      IDX_STAT2:   begin rdSel = RD_STAT2;   strb.wrStat2   = busWe; end
      IDX_BAUDINC: begin                     strb.wrBaudInc = busWe; end
      IDX_BAUDMOD: begin rdSel = RD_BAUDMOD; strb.wrBaudMod = busWe; end
      IDX_BAUDCNT: begin rdSel = RD_BAUDCNT; end
      IDX_ONEMS:   begin rdSel = RD_ONEMS;   strb.wrOneMs   = busWe; end
      IDX_TEST:    begin rdSel = RD_TEST;    end
      default: begin
        for (int i = 0; i < NUM_CTRL; i++) begin
          if (idx == 32'(IDX_CTRL1 + i)) begin
            rdSel         = RD_CTRL;
            ctrlSel       = CSEL_W'(i);
            strb.wrCtrl[i] = busWe;
          end
        end
      end
    endcase
    strb.softRst = strb.wrCtrl[1] && !srstBit;
  end

endmodule

// File: rtl/serial_regfront_dp.sv
module serial_regfront_dp
  import serial_regfront_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  rd_sel_e           rdSel,
  input  logic [CSEL_W-1:0] ctrlSel,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              txValid,
  input  logic              txReady,
  output logic [CHAR_W-1:0] txData,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic [CHAR_W-1:0] rxData,
  input  logic              rxBreak,
  output logic              irq
);
  logic [REG_W-1:0] wData;
  logic             unusedHiData;
  assign wData        = busWdata[REG_W-1:0];
  assign unusedHiData = ^busWdata[DATA_W-1:REG_W];

  // ---------------- control words (repeated structure)
  logic [REG_W-1:0] ctrlQ [NUM_CTRL];

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
    localparam logic [REG_W-1:0] CRST = (g == 0) ? REG_W'(1 << B_ENABLE) : '0;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               ctrlQ[g] <= CRST;
      else if (strb.wrCtrl[g]) ctrlQ[g] <= wData;
    end
  end

  // ---------------- plain read-back words
  logic [REG_W-1:0] fifoQ, baudCntQ, baudModQ, oneMsQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoQ    <= '0;
      baudCntQ <= '0;
      baudModQ <= '0;
      oneMsQ   <= '0;
    end else begin
      if (strb.wrFifo)    fifoQ    <= wData;
      if (strb.wrBaudInc) baudCntQ <= wData;
      if (strb.wrBaudMod) baudModQ <= wData;
      if (strb.wrOneMs)   oneMsQ   <= wData;
    end
  end

  // ---------------- status, receive buffer, transmit holding
  logic [REG_W-1:0]  stat1Q, stat2Q, testQ, rxWordQ;
  logic [REG_W-1:0]  stat1D, stat2D, testD, rxWordD;
  logic              txPendQ, txPendD;
  logic [CHAR_W-1:0] txByteQ, txByteD;
  logic              rxAccept, txDone, txStart, rxTake;

  assign rxReady  = !stat1Q[B_RXRDY];
  assign rxAccept = rxValid && rxReady;
  assign txDone   = txPendQ && txReady;
  assign txStart  = strb.wrTx && ctrlQ[1][B_TXEN] && !txPendQ;
  assign rxTake   = strb.rdRx && !testQ[B_TS_RXEMPTY];

  always_comb begin
    stat1D  = stat1Q;
    stat2D  = stat2Q;
    testD   = testQ;
    rxWordD = rxWordQ;
    txPendD = txPendQ;
    txByteD = txByteQ;
    if (strb.wrStat1) stat1D = stat1D & ~(wData & STAT1_W1C);
    if (strb.wrStat2) stat2D = stat2D & ~(wData & STAT2_W1C);
    if (txDone) begin
      txPendD            = 1'b0;
      stat1D[B_TXRDY]    = 1'b1;
      stat2D[B_TXDONE]   = 1'b1;
    end
    if (txStart) begin
      txPendD            = 1'b1;
      txByteD            = wData[CHAR_W-1:0];
      stat1D[B_TXRDY]    = 1'b0;
      stat2D[B_TXDONE]   = 1'b0;
    end
    if (rxTake) begin
      stat1D[B_RXRDY]      = 1'b0;
      stat2D[B_DATARDY]    = 1'b0;
      testD[B_TS_RXEMPTY]  = 1'b1;
    end
    if (rxAccept) begin
      stat1D[B_RXRDY]      = 1'b1;
      stat2D[B_DATARDY]    = 1'b1;
      testD[B_TS_RXEMPTY]  = 1'b0;
      if (rxBreak) begin
        rxWordD          = BRK_WORD;
        stat2D[B_BRKDET] = 1'b1;
      end else begin
        rxWordD = REG_W'(rxData);
      end
    end
    if (strb.softRst) begin
      stat1D  = STAT1_RST;
      stat2D  = STAT2_RST;
      testD   = TEST_RST;
      rxWordD = RXW_RST;
      txPendD = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stat1Q  <= STAT1_RST;
      stat2Q  <= STAT2_RST;
      testQ   <= TEST_RST;
      rxWordQ <= RXW_RST;
      txPendQ <= 1'b0;
      txByteQ <= '0;
    end else begin
      stat1Q  <= stat1D;
      stat2Q  <= stat2D;
      testQ   <= testD;
      rxWordQ <= rxWordD;
      txPendQ <= txPendD;
      txByteQ <= txByteD;
    end
  end

  assign txValid = txPendQ;
  assign txData  = txByteQ;

  // ---------------- interrupt: flags ANDed with same-position enables
  logic [REG_W-1:0] stat2Mask;
  always_comb begin
    stat2Mask = ctrlQ[C4_SLOT] & C4_IRQ_MASK;
    if (ctrlQ[0][B_TXEMPTYIE]) stat2Mask[B_TXEMPTY] = 1'b1;
  end
  assign irq = (|(stat1Q & ctrlQ[0] & S1_IRQ_MASK)) || (|(stat2Q & stat2Mask));

  // ---------------- read mux
  logic [REG_W-1:0] rdVal;
  always_comb begin
    case (rdSel)
      RD_RXWORD:  rdVal = rxWordQ;
      RD_CTRL:    rdVal = ctrlQ[ctrlSel];
      RD_FIFO:    rdVal = fifoQ;
      RD_STAT1:   rdVal = stat1Q;
      RD_STAT2:   rdVal = stat2Q;
      RD_BAUDMOD: rdVal = baudModQ;
      RD_BAUDCNT: rdVal = baudCntQ;
      RD_ONEMS:   rdVal = oneMsQ;
      RD_TEST:    rdVal = testQ;
      default:    rdVal = '0;
    endcase
  end
  assign busRdata = DATA_W'(rdVal);

  // ---------------- assertions
  // R4: a full buffer is never overwritten
  a_r4_hold_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (stat1Q[B_RXRDY] && !strb.rdRx && !strb.softRst) |=> $stable(rxWordQ));

  // R5: a read of a non-empty buffer empties it
  a_r5_read_empties: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdRx && !testQ[B_TS_RXEMPTY] && !strb.softRst) |=>
      (testQ[B_TS_RXEMPTY] && !stat1Q[B_RXRDY] && !stat2Q[B_DATARDY]));

  // R7: a pending byte stays stable until taken
  a_r7_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady && !strb.softRst) |=> (txValid && $stable(txData)));

  // R7: transmit-ready is low while a byte is pending
  a_r7_flag_low: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (!stat1Q[B_TXRDY] && !stat2Q[B_TXDONE]));

  // R9: with every enable clear the line stays low
  a_r9_quiet_irq: assert property (@(posedge clk) disable iff (!rstN)
    (!(|(ctrlQ[0] & S1_IRQ_MASK)) && !ctrlQ[0][B_TXEMPTYIE] &&
     !(|(ctrlQ[C4_SLOT] & C4_IRQ_MASK))) |-> !irq);

  // R10: soft reset restores status and drops the transmit byte
  a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rstN)
    strb.softRst |=> (stat1Q == STAT1_RST && stat2Q == STAT2_RST && !txValid));

endmodule

// File: rtl/serial_regfront.sv
module serial_regfront
  import serial_regfront_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              txValid,
  input  logic              txReady,
  output logic [CHAR_W-1:0] txData,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic [CHAR_W-1:0] rxData,
  input  logic              rxBreak,
  output logic              irq
);
  strobe_t           strb;
  rd_sel_e           rdSel;
  logic [CSEL_W-1:0] ctrlSel;

  serial_regfront_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .busRe   (busRe),
    .srstBit (busWdata[B_SRSTN]),
    .strb    (strb),
    .rdSel   (rdSel),
    .ctrlSel (ctrlSel)
  );

  serial_regfront_dp #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rdSel    (rdSel),
    .ctrlSel  (ctrlSel),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .txValid  (txValid),
    .txReady  (txReady),
    .txData   (txData),
    .rxValid  (rxValid),
    .rxReady  (rxReady),
    .rxData   (rxData),
    .rxBreak  (rxBreak),
    .irq      (irq)
  );

endmodule

// File: tb/serial_regfront_tb.sv
module serial_regfront_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        txValid;
  logic        txReady = 1'b0;
  logic [7:0]  txData;
  logic        rxValid = 1'b0;
  logic        rxReady;
  logic [7:0]  rxData = '0;
  logic        rxBreak = 1'b0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serial_regfront u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .txValid(txValid), .txReady(txReady),
    .txData(txData), .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData),
    .rxBreak(rxBreak), .irq(irq)
  );

  typedef struct packed {
    logic [11:0] wAddr;
    logic [31:0] wData;
    logic [11:0] rAddr;
    logic [31:0] expRd;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{12'h080, 32'hABCD_1234, 12'h080, 32'h0000_1234, 8'd1},  // R1 control 1
    '{12'h084, 32'h0001_5A5B, 12'h084, 32'h0000_5A5B, 8'd1},  // R1 control 2
    '{12'h088, 32'hFFFF_FFFF, 12'h088, 32'h0000_FFFF, 8'd1},  // R1 control 3
    '{12'h08F, 32'h0000_0055, 12'h08C, 32'h0000_0055, 8'd1},  // R1 low addr bits ignored
    '{12'h090, 32'h1234_0801, 12'h090, 32'h0000_0801, 8'd1},  // R1 FIFO control
    '{12'h0A8, 32'h00C3_0077, 12'h0A8, 32'h0000_0077, 8'd1},  // R1 baud modulator
    '{12'h0A4, 32'h1111_2222, 12'h0AC, 32'h0000_2222, 8'd1},  // R1 inc -> count
    '{12'h0AC, 32'h0000_9999, 12'h0AC, 32'h0000_2222, 8'd2},  // R2 count write ignored
    '{12'h0A4, 32'h0000_3333, 12'h0A4, 32'h0000_0000, 8'd2},  // R2 inc reads 0
    '{12'h0B0, 32'h0000_BEEF, 12'h0B0, 32'h0000_BEEF, 8'd1},  // R1 one-ms
    '{12'h0B4, 32'h0000_FFFF, 12'h0B4, 32'h0000_0060, 8'd2},  // R2 test status ignored
    '{12'h03C, 32'h0000_1234, 12'h03C, 32'h0000_0000, 8'd2}   // R2 unknown index
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    #1 v = busRdata;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic rxPut(input logic [7:0] d, input logic brk);
    @(negedge clk);
    rxValid = 1'b1; rxData = d; rxBreak = brk;
    @(negedge clk);
    rxValid = 1'b0; rxBreak = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (2) @(negedge clk);
    rstN = 1'b1;

    // table walk: R1 / R2
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i].wAddr, VEC[i].wData);
      rd(VEC[i].rAddr, v);
      chk($sformatf("R%0d vec%0d", VEC[i].req, i), v, VEC[i].expRd);
    end

    // R3 reset values
    doReset();
    rd(12'h094, v); chk("R3 stat1", v, 32'h2040);
    rd(12'h098, v); chk("R3 stat2", v, 32'h4028);
    rd(12'h0B4, v); chk("R3 test", v, 32'h0060);
    rd(12'h080, v); chk("R3 ctrl1", v, 32'h0001);
    rd(12'h084, v); chk("R3 ctrl2", v, 32'h0000);
    chk("R3 irq", 32'(irq), 32'd0);
    chk("R3 rxReady", 32'(rxReady), 32'd1);

    // R5 read while empty: word returned, nothing changes (also R11 same-cycle data)
    rd(12'h000, v); chk("R5 empty word", v, 32'h8000);
    rd(12'h094, v); chk("R5 empty stat1", v, 32'h2040);
    rd(12'h0B4, v); chk("R5 empty test", v, 32'h0060);

    // R4 accept, then offer while full
    rxPut(8'h41, 1'b0);
    chk("R4 rxReady low", 32'(rxReady), 32'd0);
    rd(12'h094, v); chk("R4 stat1", v, 32'h2240);
    rd(12'h098, v); chk("R4 stat2", v, 32'h4029);
    rd(12'h0B4, v); chk("R4 test", v, 32'h0040);
    rxPut(8'h42, 1'b0);
    rd(12'h000, v); chk("R4 kept first char", v, 32'h0041);
    rd(12'h094, v); chk("R5 stat1 after read", v, 32'h2040);
    rd(12'h098, v); chk("R5 stat2 after read", v, 32'h4028);
    rd(12'h0B4, v); chk("R5 test after read", v, 32'h0060);
    chk("R4 rxReady again", 32'(rxReady), 32'd1);

    // R6 break, R8 write-one-clear
    rxPut(8'h55, 1'b1);
    rd(12'h098, v); chk("R6 stat2 break", v, 32'h402D);
    rd(12'h000, v); chk("R6 break word", v, 32'h9800);
    rd(12'h098, v); chk("R6 stat2 after read", v, 32'h402C);
    wr(12'h098, 32'hFFFF);
    rd(12'h098, v); chk("R8 stat2 clear", v, 32'h4028);
    wr(12'h094, 32'hFFFF);
    rd(12'h094, v); chk("R8 stat1 kept", v, 32'h2040);
    rxPut(8'h10, 1'b0);
    wr(12'h098, 32'hFFFF);
    rd(12'h098, v); chk("R8 data-ready kept", v, 32'h4029);
    rd(12'h000, v); chk("R8 char", v, 32'h0010);

    // R9 interrupt sources
    wr(12'h08C, 32'h0001);
    chk("R9 dren empty", 32'(irq), 32'd0);
    rxPut(8'h22, 1'b0);
    chk("R9 dren data", 32'(irq), 32'd1);
    rd(12'h000, v);
    chk("R9 dren cleared", 32'(irq), 32'd0);
    wr(12'h08C, 32'h0000);
    wr(12'h080, 32'h2001);
    chk("R9 txrdy enable", 32'(irq), 32'd1);
    wr(12'h080, 32'h0041);
    chk("R9 txempty enable", 32'(irq), 32'd1);
    wr(12'h080, 32'h0201);
    chk("R9 rxrdy idle", 32'(irq), 32'd0);
    rxPut(8'h23, 1'b0);
    chk("R9 rxrdy data", 32'(irq), 32'd1);
    rd(12'h000, v);
    chk("R9 rxrdy read", 32'(irq), 32'd0);
    wr(12'h080, 32'h0001);
    wr(12'h08C, 32'h0008);
    chk("R9 tcen", 32'(irq), 32'd1);

    // R7 transmit
    wr(12'h084, 32'h0001);
    wr(12'h040, 32'h005A);
    chk("R7 disabled no valid", 32'(txValid), 32'd0);
    rd(12'h094, v); chk("R7 disabled stat1", v, 32'h2040);
    wr(12'h084, 32'h0005);
    wr(12'h040, 32'h00A5);
    chk("R7 valid", 32'(txValid), 32'd1);
    chk("R7 data", 32'(txData), 32'h00A5);
    chk("R9 tcen pending", 32'(irq), 32'd0);
    rd(12'h094, v); chk("R7 stat1 pending", v, 32'h0040);
    rd(12'h098, v); chk("R7 stat2 pending", v, 32'h4020);
    wr(12'h040, 32'h0077);
    chk("R7 second write dropped", 32'(txData), 32'h00A5);
    @(negedge clk); txReady = 1'b1;
    @(negedge clk); txReady = 1'b0;
    chk("R7 handshake done", 32'(txValid), 32'd0);
    rd(12'h094, v); chk("R7 stat1 done", v, 32'h2040);
    rd(12'h098, v); chk("R7 stat2 done", v, 32'h4028);
    chk("R9 tcen done", 32'(irq), 32'd1);

    // R10 soft reset
    rxPut(8'h33, 1'b0);
    wr(12'h040, 32'h0011);
    chk("R10 pre pending", 32'(txValid), 32'd1);
    wr(12'h084, 32'h0004);
    chk("R10 tx dropped", 32'(txValid), 32'd0);
    rd(12'h094, v); chk("R10 stat1", v, 32'h2040);
    rd(12'h098, v); chk("R10 stat2", v, 32'h4028);
    rd(12'h0B4, v); chk("R10 test", v, 32'h0060);
    rd(12'h000, v); chk("R10 rx word", v, 32'h8000);
    rd(12'h084, v); chk("R10 ctrl2 value", v, 32'h0004);
    rd(12'h08C, v); chk("R10 ctrl4 kept", v, 32'h0008);
    rd(12'h080, v); chk("R10 ctrl1 kept", v, 32'h0001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule